// File: doc/BRIEF.md
# Fractional-N Divide Ratio Controller

This block steers the feedback divider of a fractional-N frequency synthesiser so that, averaged over many comparison cycles, the output runs at `fCOMP × (NTOT + NF/MOD)`. Each comparison strobe adds the fractional numerator to a small modulo accumulator. The modulus is either 5 or 8. When the addition wraps, the divider runs one cycle at NTOT+1. Otherwise it runs at NTOT. The block also contains the programmable feedback counter itself. That counter counts input ticks and emits one pulse per completed division, using whichever ratio is currently selected.

The accumulator residue after each addition is proportional to the phase error that the alternating ratio builds up on the loop filter. The reference phase is the NTOT+1 cycle that leaves the residue at zero. The cancellation charge then works out to residue × SF / MOD, which does not depend on NTOT. The block outputs the full-width product residue × SF as a compensation code. A flag beside it tells the downstream DAC whether to scale by one fifth or one eighth. The scale factor comes from one of two inputs, chosen by the speed-up mode flag, so the code follows the pump current that is active.

Top module: `fracn_ratio_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the following outputs are cleared after that edge: `residue`, `div_plus1`, `comp_code`, `comp_div8` and `fb_pulse`. The feedback tick count also restarts from zero.
- R2: On a clock edge with `cmp_stb` high, the effective numerator is added to the residue. If the sum is at least the modulus, `residue` becomes sum − modulus and `div_plus1` becomes 1. Otherwise `residue` becomes the sum and `div_plus1` becomes 0.
- R3: `mod_sel8` = 1 selects modulus 8 and `mod_sel8` = 0 selects modulus 5. The select is read at each strobe.
- R4: A `frac_num` value at or above the modulus is used as modulus − 1.
- R5: On an edge with `cmp_stb` low, the following outputs hold their values: `residue`, `div_plus1`, `comp_code` and `comp_div8`.
- R6: If the stored residue is at or above the modulus in force at a strobe, it is taken as 0 before the addition. This can happen after the modulus is switched from 8 to 5.
- R7: On a strobe, `comp_code` becomes the new residue times the active scale. The active scale is `sf_fast` when `speedup` = 1 and `sf_norm` otherwise. On the same strobe, `comp_div8` takes the value of `mod_sel8`. Neither output depends on `ntot`.
- R8: With `frac_num` = 3 and modulus 8, starting from residue 0, successive strobes give residues 3, 6, 1, 4, 7, 2, 5, 0. `div_plus1` is 1 exactly on the steps that give 1, 2 and 0.
- R9: The feedback counter counts edges on which `fb_tick` is high. On the tick that brings the count since the last terminal to the ratio `ntot` + `div_plus1`, it restarts the count, and `fb_pulse` is high for the one clock that follows. The ratio is evaluated at that tick.
- R10: A ratio of 0 or 1 makes every tick a terminal tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_stb | input | 1 | Comparison-cycle strobe |
| ntot | input | 10 | Integer divide ratio |
| frac_num | input | 3 | Fractional numerator |
| mod_sel8 | input | 1 | 1: modulus 8, 0: modulus 5 |
| sf_norm | input | 6 | Scale factor, normal mode |
| sf_fast | input | 6 | Scale factor, speed-up mode |
| speedup | input | 1 | Speed-up mode active |
| fb_tick | input | 1 | Feedback counter count enable (one per VCO period) |
| residue | output | 3 | Accumulator value after the last strobe |
| div_plus1 | output | 1 | Divide by ntot+1 this comparison cycle |
| fb_pulse | output | 1 | Divider terminal pulse |
| comp_code | output | 9 | Compensation code, residue × scale |
| comp_div8 | output | 1 | DAC scaling select, 1: divide by 8, 0: divide by 5 |

## Verification
Every cycle, the assertions check the following. After a strobe, the residue is below the modulus that strobe used. The residue, ratio select and compensation code do not move without a strobe. A zero numerator never produces a ratio of NTOT+1. A zero active scale yields a zero code. A terminal pulse appears only after a tick, and then with the count cleared. Only the bench scenarios can show the arithmetic itself: the exact residue sequences, the clamp of oversized numerators, the zero substitution after a modulus switch, the choice between the two scale factors, and the spacing of divider pulses in ticks. For these, a cycle-level reference model runs under random stimulus, and directed runs compare against the listed modulo-8 sequence and the small-ratio cases.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    parameter int NTOT_W = 10;
    parameter int SF_W   = 6;
    parameter int ACC_W  = 3;
    localparam int WIDE_W = ACC_W + 1;
    localparam int CODE_W = ACC_W + SF_W;
    localparam int RAT_W  = NTOT_W + 1;

    typedef logic [ACC_W-1:0]  acc_t;
    typedef logic [WIDE_W-1:0] wide_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        acc_t acc;
        logic plus1;
    } acc_state_t;

    typedef struct packed {
        code_t code;
        logic  div8;
    } comp_state_t;

    function automatic wide_t modulus_of(input logic sel8);
        return sel8 ? wide_t'(8) : wide_t'(5);
    endfunction

    function automatic wide_t clamp_num(input acc_t num, input wide_t m);
        wide_t n;
        n = wide_t'(num);
        return (n >= m) ? (m - wide_t'(1)) : n;
    endfunction

endpackage

// File: rtl/fracn_accum.sv
module fracn_accum
    import fracn_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stb,
    input  acc_t       num,
    input  logic       sel8,
    output acc_state_t st_q,
    output acc_t       acc_next
);
    wide_t m, num_eff, base, total, folded;
    logic  wrap;
    acc_state_t st_d;

    always_comb begin
        m       = modulus_of(sel8);
        num_eff = clamp_num(num, m);
        base    = (wide_t'(st_q.acc) >= m) ? '0 : wide_t'(st_q.acc);
        total   = base + num_eff;
        folded  = total - m;
        wrap    = (total >= m);
        acc_next = wrap ? folded[ACC_W-1:0] : total[ACC_W-1:0];
        st_d.acc   = acc_next;
        st_d.plus1 = wrap;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else if (stb)
            st_q <= st_d;
    end

    // R2
    acc_below_mod_chk: assert property (@(posedge clk) disable iff (rst)
        stb |=> (wide_t'(st_q.acc) < $past(m)));

    // R5
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stb |=> ($stable(st_q.acc) && $stable(st_q.plus1)));

    // R4
    zero_num_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && num == '0) |=> !st_q.plus1);

endmodule

// File: rtl/fracn_comp.sv
module fracn_comp
    import fracn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  acc_t              acc_new,
    input  logic [SF_W-1:0]   sf_norm,
    input  logic [SF_W-1:0]   sf_fast,
    input  logic              fast,
    input  logic              sel8,
    output comp_state_t       cs_q
);
    logic [SF_W-1:0] scale;
    comp_state_t cs_d;

    always_comb begin
        scale     = fast ? sf_fast : sf_norm;
        cs_d.code = code_t'(acc_new) * code_t'(scale);
        cs_d.div8 = sel8;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cs_q <= '0;
        else if (stb)
            cs_q <= cs_d;
    end

    // R7
    zero_scale_chk: assert property (@(posedge clk) disable iff (rst)
        (stb && ((fast ? sf_fast : sf_norm) == '0)) |=> (cs_q.code == '0));

    // R5
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stb |=> ($stable(cs_q.code) && $stable(cs_q.div8)));

endmodule

// File: rtl/fracn_fbdiv.sv
module fracn_fbdiv
    import fracn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [NTOT_W-1:0] ntot,
    input  logic              plus1,
    output logic              pulse_q
);
    localparam int CW = RAT_W + 1;
    logic [CW-1:0] cnt_q, ratio, cnt_inc;
    logic          term;

    always_comb begin
        ratio   = CW'(ntot) + CW'(plus1);
        cnt_inc = cnt_q + CW'(1);
        term    = (cnt_inc >= ratio);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (tick) begin
            cnt_q   <= term ? '0 : cnt_inc;
            pulse_q <= term;
        end else begin
            pulse_q <= 1'b0;
        end
    end

    // R9
    pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !pulse_q);

    // R9
    pulse_clears_count_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> (cnt_q == '0));

endmodule

// File: rtl/fracn_ratio_ctrl.sv
module fracn_ratio_ctrl
    import fracn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_stb,
    input  logic [NTOT_W-1:0] ntot,
    input  logic [ACC_W-1:0]  frac_num,
    input  logic              mod_sel8,
    input  logic [SF_W-1:0]   sf_norm,
    input  logic [SF_W-1:0]   sf_fast,
    input  logic              speedup,
    input  logic              fb_tick,
    output logic [ACC_W-1:0]  residue,
    output logic              div_plus1,
    output logic              fb_pulse,
    output logic [CODE_W-1:0] comp_code,
    output logic              comp_div8
);
    acc_state_t  acc_st;
    acc_t        acc_nx;
    comp_state_t comp_st;

    fracn_accum u_accum (
        .clk      (clk),
        .rst      (rst),
        .stb      (cmp_stb),
        .num      (frac_num),
        .sel8     (mod_sel8),
        .st_q     (acc_st),
        .acc_next (acc_nx)
    );

    fracn_comp u_comp (
        .clk     (clk),
        .rst     (rst),
        .stb     (cmp_stb),
        .acc_new (acc_nx),
        .sf_norm (sf_norm),
        .sf_fast (sf_fast),
        .fast    (speedup),
        .sel8    (mod_sel8),
        .cs_q    (comp_st)
    );

    fracn_fbdiv u_fbdiv (
        .clk     (clk),
        .rst     (rst),
        .tick    (fb_tick),
        .ntot    (ntot),
        .plus1   (acc_st.plus1),
        .pulse_q (fb_pulse)
    );

    assign residue   = acc_st.acc;
    assign div_plus1 = acc_st.plus1;
    assign comp_code = comp_st.code;
    assign comp_div8 = comp_st.div8;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (residue == '0 && !div_plus1 && !fb_pulse && comp_code == '0));

endmodule

// File: tb/tb_fracn_ratio_ctrl.sv
`timescale 1ns/1ps
module tb_fracn_ratio_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_stb = 1'b0;
    logic [9:0] ntot = 10'd4;
    logic [2:0] frac_num = '0;
    logic       mod_sel8 = 1'b0;
    logic [5:0] sf_norm = '0, sf_fast = '0;
    logic       speedup = 1'b0;
    logic       fb_tick = 1'b0;
    logic [2:0] residue;
    logic       div_plus1, fb_pulse, comp_div8;
    logic [8:0] comp_code;

    int checks = 0, bad = 0;
    int m_acc = 0, m_p1 = 0, m_code = 0, m_d8 = 0, m_cnt = 0, m_pulse = 0;

    always #2 clk = ~clk;

    fracn_ratio_ctrl dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int modv(input logic s8);
        return s8 ? 8 : 5;
    endfunction

    // Reference model of one clock edge, inputs as currently driven.
    task automatic model_edge();
        int m, n, b, s, ratio;
        if (rst) begin
            m_acc = 0; m_p1 = 0; m_code = 0; m_d8 = 0; m_cnt = 0; m_pulse = 0;
            return;
        end
        ratio = int'(ntot) + m_p1;
        if (fb_tick) begin
            if (m_cnt + 1 >= ratio) begin m_cnt = 0; m_pulse = 1; end
            else begin m_cnt = m_cnt + 1; m_pulse = 0; end
        end else m_pulse = 0;
        if (cmp_stb) begin
            m = modv(mod_sel8);
            n = (int'(frac_num) >= m) ? m - 1 : int'(frac_num);
            b = (m_acc >= m) ? 0 : m_acc;
            s = b + n;
            m_p1 = (s >= m) ? 1 : 0;
            m_acc = (s >= m) ? s - m : s;
            m_code = m_acc * int'(speedup ? sf_fast : sf_norm);
            m_d8 = int'(mod_sel8);
        end
    endtask

    task automatic step();
        model_edge();
        @(negedge clk);
    endtask

    task automatic compare_all();
        chk(int'(residue) == m_acc, "R2 residue", int'(residue), m_acc);
        chk(int'(div_plus1) == m_p1, "R2 div_plus1", int'(div_plus1), m_p1);
        chk(int'(comp_code) == m_code, "R7 comp_code", int'(comp_code), m_code);
        chk(int'(comp_div8) == m_d8, "R7 comp_div8", int'(comp_div8), m_d8);
        chk(int'(fb_pulse) == m_pulse, "R9 fb_pulse", int'(fb_pulse), m_pulse);
    endtask

    task automatic do_reset();
        rst = 1'b1; step(); step(); rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int seed;
        int seq[8] = '{3, 6, 1, 4, 7, 2, 5, 0};
        int wr[8]  = '{0, 0, 1, 0, 0, 1, 0, 1};
        int gap;
        seed = 1234;
        void'($urandom(seed));
        @(negedge clk);
        // R1: reset with active stimulus
        cmp_stb = 1; frac_num = 3; sf_norm = 9; fb_tick = 1;
        step(); step();
        chk(residue == 0 && !div_plus1 && comp_code == 0 && !fb_pulse && !comp_div8,
            "R1 reset state", int'(residue), 0);
        rst = 0; cmp_stb = 0; fb_tick = 0;

        // R8: listed modulus-8 sequence, sf=1 shows residue in the code
        mod_sel8 = 1; frac_num = 3; sf_norm = 1; speedup = 0;
        for (int i = 0; i < 8; i++) begin
            cmp_stb = 1; step();
            chk(int'(residue) == seq[i], "R8 residue", int'(residue), seq[i]);
            chk(int'(div_plus1) == wr[i], "R8 div_plus1", int'(div_plus1), wr[i]);
            chk(int'(comp_code) == seq[i], "R7 code tracks residue", int'(comp_code), seq[i]);
        end

        // R5: no strobe, change every input
        cmp_stb = 0; frac_num = 7; sf_norm = 33; mod_sel8 = 0;
        step(); step();
        compare_all();
        chk(residue == 0 && comp_div8 == 1, "R5 hold", int'(residue), 0);

        // R3 and R4: modulus 5 with clamped numerator 7 -> 4
        cmp_stb = 1; mod_sel8 = 0; frac_num = 7; sf_norm = 2;
        step();
        chk(residue == 4 && !div_plus1, "R4 clamp first", int'(residue), 4);
        step();
        chk(residue == 3 && div_plus1, "R3 wrap at 5", int'(residue), 3);
        chk(comp_code == 6 && !comp_div8, "R7 scale normal", int'(comp_code), 6);

        // R6: residue 7 under modulus 8, then switch to 5
        mod_sel8 = 1; frac_num = 4; step();   // 3+4=7
        chk(residue == 7, "R6 setup", int'(residue), 7);
        mod_sel8 = 0; frac_num = 2; speedup = 1; sf_fast = 5; step();
        chk(residue == 2 && !div_plus1, "R6 zero substitute", int'(residue), 2);
        chk(comp_code == 10, "R7 speed-up scale", int'(comp_code), 10);

        // R10: ratio 0 and 1 pulse on every tick
        do_reset();
        cmp_stb = 0; fb_tick = 1;
        for (int r = 0; r < 2; r++) begin
            ntot = 10'(r);
            for (int i = 0; i < 4; i++) begin
                step();
                chk(fb_pulse == 1, "R10 every tick", int'(fb_pulse), 1);
            end
        end

        // R9: ratio ntot, then ntot+1
        do_reset();
        ntot = 6; fb_tick = 1;
        gap = 0;
        for (int i = 0; i < 13; i++) begin
            step(); gap++;
            if (fb_pulse) begin
                chk(gap == 6, "R9 period ntot", gap, 6);
                gap = 0;
            end
        end
        fb_tick = 0; cmp_stb = 1; mod_sel8 = 1; frac_num = 7; step(); // residue 7 -> no wrap
        frac_num = 1; step(); cmp_stb = 0;                            // wraps -> plus1
        chk(div_plus1 == 1, "R9 plus1 set", int'(div_plus1), 1);
        do_reset(); ntot = 6;
        cmp_stb = 1; frac_num = 7; step(); frac_num = 1; step(); cmp_stb = 0;
        fb_tick = 1; gap = 0;
        for (int i = 0; i < 15; i++) begin
            step(); gap++;
            if (fb_pulse) begin
                chk(gap == 7, "R9 period ntot+1", gap, 7);
                gap = 0;
            end
        end

        // Random run against the reference model (R2 R3 R4 R5 R6 R7 R9)
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            cmp_stb  = ($urandom % 10) < 4;
            fb_tick  = ($urandom % 10) < 7;
            frac_num = 3'($urandom);
            if (($urandom % 16) == 0) mod_sel8 = ~mod_sel8;
            sf_norm  = 6'($urandom);
            sf_fast  = 6'($urandom);
            speedup  = 1'($urandom);
            if (($urandom % 50) == 0) ntot = 10'(2 + $urandom % 12);
            step();
            compare_all();
        end

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule